// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a bus master and a memory port. It claims two 32 MB alias windows. In each window, every aligned 32-bit alias word stands for exactly one bit of a real memory region. A read through an alias word costs one real read, and the master gets back a single 0 or 1. A write through an alias word becomes a read-modify-write on the real location. It sets or clears that one bit and leaves every other bit as it was.

Both sides use the same plain request/response handshake. A request carries address, size, write flag and write data under valid/ready. A response is a one-cycle valid with read data. The bridge keeps the read and the write-back of one alias write together: it takes no new upstream request until the response for the current one has been given. An address outside both windows is not accepted, and a decode-miss flag marks it.

Top module: `bitband_bridge`

## Requirements
- R1: With the bridge idle, `upReqReady` is high exactly when `upAddr` lies in an alias window (window 0 at 0x2200_0000 and window 1 at 0x4200_0000, each 0x0200_0000 bytes). An accepted request starts a downstream read on the following cycle.
- R2: The downstream address is the window's real base (0x2000_0000 for window 0, 0x4000_0000 for window 1) ORed with the low 25 address bits shifted right by 5.
- R3: The bit number comes from address bits upward of bit 2. A byte access (`upSize`=0) uses 3 bits, a halfword (`upSize`=1) 4 bits and a word (`upSize`=2) 5 bits. The bit is placed on little-endian 32-bit data lanes: lane k holds the byte at address offset k in bits 8k+7:8k, so a byte bit lands at 8*addr[1:0]+n and a halfword bit at 16*addr[1]+n.
- R4: For a halfword access, downstream address bit 0 is forced to 0. For a word access, bits 1:0 are forced to 0. The downstream size equals the upstream size.
- R5: An alias read issues one downstream read and no write. It responds with bit 0 equal to the selected bit and all other bits 0.
- R6: An alias write reads the real location and then writes it back with the same address and size. The selected bit becomes bit 0 of `upWdata` and all other memory bits are unchanged. Write data bits 31:1 have no effect, and the write response data is 0.
- R7: From acceptance until the response, `upReqReady` stays low and no other downstream request is issued between the read and the write-back.
- R8: A valid request outside both windows raises `upMiss`, is never accepted and causes no downstream traffic.
- R9: After reset, no request or response is valid. Each access ends with a single-cycle `upRspValid` pulse.
- R10: A downstream request that is not yet accepted stays valid with stable address, write flag and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| upReqValid | input | 1 | Upstream request valid |
| upReqReady | output | 1 | Upstream request accepted |
| upAddr | input | 32 | Upstream byte address |
| upSize | input | 2 | 0 byte, 1 halfword, 2 word |
| upWrite | input | 1 | Upstream write flag |
| upWdata | input | 32 | Upstream write data (bit 0 used) |
| upRspValid | output | 1 | Upstream response pulse |
| upRspData | output | 32 | Upstream read result |
| upMiss | output | 1 | Valid request outside both windows |
| dnReqValid | output | 1 | Downstream request valid |
| dnReqReady | input | 1 | Downstream request accepted |
| dnAddr | output | 32 | Downstream real byte address |
| dnSize | output | 2 | Downstream size |
| dnWrite | output | 1 | Downstream write flag |
| dnWdata | output | 32 | Downstream write data, lane ordered |
| dnRspValid | input | 1 | Downstream response valid |
| dnRspData | input | 32 | Downstream read data, lane ordered |

## Verification
Two functions can meet in the same cycle: a new upstream request being offered, and the read-modify-write sequence of an earlier alias write that is still in flight. The bench provokes this by holding an in-window address on the upstream bus while the memory model stalls every other request cycle. It then judges that `upReqReady` stays low in every sampled cycle until the response pulse, and that the downstream log holds exactly one read followed by one write-back to the same address. A second overlap, a decode miss presented while idle, is judged by `upMiss` high, `upReqReady` low and an empty downstream log.

// File: rtl/bbb_pkg.sv
package bbb_pkg;
  localparam int DATA_W = 32;
  localparam int POS_W  = $clog2(DATA_W);

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [2:0] {
    IDLE, RD_REQ, RD_WAIT, WR_REQ, WR_WAIT, RESP
  } bbState_t;

  typedef struct packed {
    logic capReq;   // latch the upstream request
    logic capRd;    // latch the fetched real data
  } bbStrobe_t;
endpackage

// File: rtl/bbb_dpath.sv
module bbb_dpath
  import bbb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2,
  parameter int WIN_LOG2 = 25,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] REAL_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rstN,
  input  bbStrobe_t         strb,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [1:0]        upSize,
  input  logic              upWrite,
  input  logic [DATA_W-1:0] upWdata,
  input  logic [DATA_W-1:0] dnRspData,
  output logic              inWin,
  output logic              isWrite,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [1:0]        dnSize,
  output logic [DATA_W-1:0] dnWdata,
  output logic [DATA_W-1:0] upRspData
);
  localparam int SHIFT = $clog2(DATA_W);

  logic [NUM_WIN-1:0] winHit;
  logic [ADDR_W-1:0]  baseSel [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] AB = ALIAS_BASES[w*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] RB = REAL_BASES[w*ADDR_W +: ADDR_W];
    assign winHit[w]  = (upAddr[ADDR_W-1:WIN_LOG2] == AB[ADDR_W-1:WIN_LOG2]);
    assign baseSel[w] = winHit[w] ? RB : '0;
  end

  assign inWin = |winHit;

  logic [ADDR_W-1:0] realBase, offset, realAddr;
  logic [POS_W-1:0]  selField, nextPos;

  always_comb begin
    realBase = '0;
    for (int w = 0; w < NUM_WIN; w++) realBase = realBase | baseSel[w];
    offset   = {{(ADDR_W-WIN_LOG2){1'b0}}, upAddr[WIN_LOG2-1:0]};
    realAddr = realBase | (offset >> SHIFT);
    selField = upAddr[2 +: POS_W];
    case (upSize)
      SZ_BYTE: nextPos = {realAddr[1:0], selField[2:0]};
      SZ_HALF: begin
        realAddr[0] = 1'b0;
        nextPos     = {realAddr[1], selField[3:0]};
      end
      default: begin
        realAddr[1:0] = 2'b00;
        nextPos       = selField;
      end
    endcase
  end

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sizeQ;
  logic              writeQ, bitQ;
  logic [POS_W-1:0]  posQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= SZ_BYTE;
      writeQ <= 1'b0;
      bitQ   <= 1'b0;
      posQ   <= '0;
      rdQ    <= '0;
    end else begin
      if (strb.capReq) begin
        addrQ  <= realAddr;
        sizeQ  <= upSize;
        writeQ <= upWrite;
        bitQ   <= upWdata[0];
        posQ   <= nextPos;
      end
      if (strb.capRd) rdQ <= dnRspData;
    end
  end

  logic [DATA_W-1:0] bitMask;
  assign bitMask   = {{(DATA_W-1){1'b0}}, 1'b1} << posQ;
  assign isWrite   = writeQ;
  assign dnAddr    = addrQ;
  assign dnSize    = sizeQ;
  assign dnWdata   = bitQ ? (rdQ | bitMask) : (rdQ & ~bitMask);
  assign upRspData = writeQ ? '0 : {{(DATA_W-1){1'b0}}, rdQ[posQ]};
endmodule

// File: rtl/bbb_ctrl.sv
module bbb_ctrl
  import bbb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      upReqValid,
  input  logic      inWin,
  input  logic      isWrite,
  input  logic      dnReqReady,
  input  logic      dnRspValid,
  output logic      upReqReady,
  output logic      upRspValid,
  output logic      dnReqValid,
  output logic      dnWrite,
  output bbStrobe_t strb
);
  bbState_t state, stateNx;

  always_comb begin
    stateNx = state;
    case (state)
      IDLE:    if (upReqValid && inWin) stateNx = RD_REQ;
      RD_REQ:  if (dnReqReady) stateNx = RD_WAIT;
      RD_WAIT: if (dnRspValid) stateNx = isWrite ? WR_REQ : RESP;
      WR_REQ:  if (dnReqReady) stateNx = WR_WAIT;
      WR_WAIT: if (dnRspValid) stateNx = RESP;
      RESP:    stateNx = IDLE;
      default: stateNx = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= IDLE;
    else       state <= stateNx;
  end

  assign upReqReady  = (state == IDLE) && inWin;
  assign upRspValid  = (state == RESP);
  assign dnReqValid  = (state == RD_REQ) || (state == WR_REQ);
  assign dnWrite     = (state == WR_REQ);
  assign strb.capReq = upReqValid && upReqReady;
  assign strb.capRd  = (state == RD_WAIT) && dnRspValid;
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bbb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_WIN  = 2,
  parameter int WIN_LOG2 = 25,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] REAL_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upReqValid,
  output logic              upReqReady,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [1:0]        upSize,
  input  logic              upWrite,
  input  logic [31:0]       upWdata,
  output logic              upRspValid,
  output logic [31:0]       upRspData,
  output logic              upMiss,
  output logic              dnReqValid,
  input  logic              dnReqReady,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [1:0]        dnSize,
  output logic              dnWrite,
  output logic [31:0]       dnWdata,
  input  logic              dnRspValid,
  input  logic [31:0]       dnRspData
);
  bbStrobe_t strb;
  logic      inWin, isWrite;

  bbb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .upReqValid(upReqValid), .inWin(inWin),
    .isWrite(isWrite), .dnReqReady(dnReqReady), .dnRspValid(dnRspValid),
    .upReqReady(upReqReady), .upRspValid(upRspValid),
    .dnReqValid(dnReqValid), .dnWrite(dnWrite), .strb(strb)
  );

  bbb_dpath #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_LOG2(WIN_LOG2),
    .ALIAS_BASES(ALIAS_BASES), .REAL_BASES(REAL_BASES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .upAddr(upAddr), .upSize(upSize),
    .upWrite(upWrite), .upWdata(upWdata), .dnRspData(dnRspData),
    .inWin(inWin), .isWrite(isWrite), .dnAddr(dnAddr), .dnSize(dnSize),
    .dnWdata(dnWdata), .upRspData(upRspData)
  );

  assign upMiss = upReqValid && !inWin;
endmodule

// File: rtl/bbb_checker.sv
module bbb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        upReqValid,
  input logic        upReqReady,
  input logic [31:0] upAddr,
  input logic [1:0]  upSize,
  input logic        upWrite,
  input logic [31:0] upWdata,
  input logic        upRspValid,
  input logic [31:0] upRspData,
  input logic        upMiss,
  input logic        dnReqValid,
  input logic        dnReqReady,
  input logic [31:0] dnAddr,
  input logic [1:0]  dnSize,
  input logic        dnWrite,
  input logic [31:0] dnWdata,
  input logic        dnRspValid,
  input logic [31:0] dnRspData
);
  // R1
  accept_starts_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    upReqValid && upReqReady |=> dnReqValid && !dnWrite);

  // R5
  rsp_single_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    upRspValid |-> upRspData[31:1] == 31'd0);

  // R7
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnReqValid || upRspValid) |-> !upReqReady);

  // R7
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    upReqValid && upReqReady |=> !upReqReady);

  // R8
  miss_not_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    upMiss |-> !upReqReady);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    upRspValid |=> !upRspValid);

  // R10
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dnReqValid && !dnReqReady |=> dnReqValid && $stable(dnAddr) &&
      $stable(dnWrite) && $stable(dnWdata) && $stable(dnSize));
endmodule

bind bitband_bridge bbb_checker u_chk (.*);

// File: tb/sim_bitband_bridge.sv
`timescale 1ns/1ps
module sim_bitband_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        upReqValid = 1'b0, upReqReady;
  logic [31:0] upAddr = '0;
  logic [1:0]  upSize = '0;
  logic        upWrite = 1'b0;
  logic [31:0] upWdata = '0;
  logic        upRspValid, upMiss;
  logic [31:0] upRspData;
  logic        dnReqValid, dnWrite;
  logic        dnReqReady = 1'b1;
  logic [31:0] dnAddr, dnWdata;
  logic [1:0]  dnSize;
  logic        dnRspValid = 1'b0;
  logic [31:0] dnRspData = '0;

  always #2 clk = ~clk;

  bitband_bridge u0 (.*);

  int checks = 0, fails = 0;
  logic [31:0] mem [2][64];
  logic [31:0] refMem [2][64];
  logic        stallMode = 1'b0;
  int          logN = 0;
  logic [31:0] logAddr [8];
  logic [1:0]  logSize [8];
  logic        logWr [8];
  logic [31:0] logData [8];

  // memory model: little-endian lanes, response one cycle after acceptance
  always @(posedge clk) begin
    dnReqReady <= stallMode ? ~dnReqReady : 1'b1;
    dnRspValid <= 1'b0;
    if (rstN && dnReqValid && dnReqReady) begin
      if (logN < 8) begin
        logAddr[logN] <= dnAddr; logSize[logN] <= dnSize;
        logWr[logN] <= dnWrite;  logData[logN] <= dnWdata;
      end
      logN <= logN + 1;
      dnRspValid <= 1'b1;
      dnRspData  <= mem[dnAddr[30]][dnAddr[7:2]];
      if (dnWrite) begin
        for (int k = 0; k < 4; k++) begin
          if (dnSize == 2'd2 || (dnSize == 2'd1 && (k >> 1) == int'(dnAddr[1])) ||
              (dnSize == 2'd0 && k == int'(dnAddr[1:0])))
            mem[dnAddr[30]][dnAddr[7:2]][8*k +: 8] <= dnWdata[8*k +: 8];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expReal(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] r;
    r = (a[31:24] == 8'h42) ? 32'h4000_0000 : 32'h2000_0000;
    r = r | ({7'd0, a[24:0]} >> 5);
    if (sz == 2'd1) r[0] = 1'b0;
    if (sz == 2'd2) r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic int expPos(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] r;
    r = expReal(a, sz);
    if (sz == 2'd0) return int'((a >> 2) & 7) + 8 * int'(r[1:0]);
    if (sz == 2'd1) return int'((a >> 2) & 15) + 16 * int'(r[1]);
    return int'((a >> 2) & 31);
  endfunction

  // one alias access; counts sampled cycles with ready high while busy
  task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int busyRdy);
    busyRdy = 0;
    logN = 0;
    @(negedge clk);
    upReqValid = 1'b1; upWrite = wr; upSize = sz; upAddr = a; upWdata = wd;
    while (!upReqReady) @(negedge clk);
    @(negedge clk);
    upReqValid = 1'b0;
    for (int n = 0; n < 40 && !upRspValid; n++) begin
      if (upReqReady) busyRdy++;
      @(negedge clk);
    end
    rd = upRspData;
    check(upRspValid == 1'b1, "R9", "response seen", {31'd0, upRspValid}, 32'd1);
    @(negedge clk);
    check(upRspValid == 1'b0, "R9", "response one cycle", {31'd0, upRspValid}, 32'd0);
  endtask

  localparam int NV = 13;
  // {write, size, alias address, write data}
  localparam logic [66:0] VEC [NV] = '{
    {1'b1, 2'd2, 32'h2200_0014, 32'h0000_0001},
    {1'b0, 2'd2, 32'h2200_0014, 32'h0000_0000},
    {1'b1, 2'd0, 32'h2200_00AC, 32'hFFFF_FFFF},
    {1'b0, 2'd1, 32'h2200_00C8, 32'h0000_0000},
    {1'b1, 2'd2, 32'h4200_0110, 32'h0000_0001},
    {1'b1, 2'd2, 32'h4200_0110, 32'hFFFF_FFFE},
    {1'b1, 2'd1, 32'h4200_01FC, 32'h0000_0001},
    {1'b0, 2'd2, 32'h4200_01FC, 32'h0000_0000},
    {1'b0, 2'd0, 32'h2200_00FC, 32'h0000_0000},
    {1'b1, 2'd2, 32'h23FF_FFFC, 32'h0000_0001},
    {1'b0, 2'd2, 32'h23FF_FFFC, 32'h0000_0000},
    {1'b1, 2'd0, 32'h2200_00AC, 32'h0000_0000},
    {1'b0, 2'd0, 32'h2200_00AC, 32'h0000_0000}
  };

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd, ra, expW;
    int busy, pos, wi, ix;
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 64; i++) begin
        mem[w][i]    = (32'h9E37_79B9 * (i + 1)) ^ (w ? 32'h5A5A_0F0F : 32'h0);
        refMem[w][i] = mem[w][i];
      end
    repeat (3) @(negedge clk);
    // R9 reset state
    check(upRspValid == 1'b0 && dnReqValid == 1'b0, "R9", "reset idle",
          {30'd0, upRspValid, dnReqValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    upAddr = 32'h2200_0000;
    @(negedge clk);
    check(upReqReady == 1'b1, "R1", "ready for window", {31'd0, upReqReady}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      logic        vw;
      logic [1:0]  vs;
      logic [31:0] va, vd;
      {vw, vs, va, vd} = VEC[v];
      stallMode = v[0];
      ra  = expReal(va, vs);
      pos = expPos(va, vs);
      wi  = int'(ra[30]);
      ix  = int'(ra[7:2]);
      access(vw, vs, va, vd, rd, busy);
      check(busy == 0, "R7", "ready low while busy", busy, 0);
      check(logN == (vw ? 2 : 1), "R5", "downstream count", logN, vw ? 2 : 1);
      check(logAddr[0] == ra, "R2", "real address", logAddr[0], ra);
      check(logSize[0] == vs && !logWr[0], "R4", "read size", {30'd0, logSize[0]}, {30'd0, vs});
      if (vw) begin
        if (vd[0]) refMem[wi][ix][pos] = 1'b1;
        else       refMem[wi][ix][pos] = 1'b0;
        check(logWr[1] && logAddr[1] == ra && logSize[1] == vs, "R6", "write-back target",
              logAddr[1], ra);
        check(logData[1][pos] == vd[0], "R3", "bit lane", logData[1], refMem[wi][ix]);
        check(mem[wi][ix] == refMem[wi][ix], "R6", "memory word", mem[wi][ix], refMem[wi][ix]);
        check(rd == 32'd0, "R6", "write rsp data", rd, 32'd0);
      end else begin
        expW = {31'd0, refMem[wi][ix][pos]};
        check(rd == expW, "R5", "read bit", rd, expW);
        check(mem[wi][ix] == refMem[wi][ix], "R5", "memory untouched", mem[wi][ix], refMem[wi][ix]);
      end
    end

    // R8 misses: between windows, just above window 0, just below window 0
    stallMode = 1'b0;
    for (int m = 0; m < 3; m++) begin
      logic [31:0] ma;
      ma = (m == 0) ? 32'h3000_0000 : (m == 1) ? 32'h2400_0000 : 32'h21FF_FFFC;
      logN = 0;
      @(negedge clk);
      upReqValid = 1'b1; upWrite = 1'b1; upSize = 2'd2; upAddr = ma; upWdata = 32'd1;
      repeat (4) @(negedge clk);
      check(upMiss == 1'b1 && upReqReady == 1'b0, "R8", "miss flagged",
            {30'd0, upMiss, upReqReady}, 32'd2);
      check(logN == 0 && upRspValid == 1'b0, "R8", "no traffic", logN, 0);
      upReqValid = 1'b0;
    end
    @(negedge clk);
    check(upMiss == 1'b0, "R8", "miss needs valid", {31'd0, upMiss}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule